// File: doc/BRIEF.md
# Token-Chained Programmable Row Steering Sequencer

This block is the digital core of a row steering chip for a pixel matrix. It drives one gate-enable line and one clear-enable line per output channel, and each channel stands for one matrix row. The order of rows comes from a small pattern memory, not from a plain counter. The pattern can leave out defective rows and can return to busy rows as often as needed. Each slot shows one memory word. A shared start strobe begins a pass, and a shared row-advance strobe (`step`) moves to the next slot.

Several chips sit in a chain and share every control line. Only the chip that holds the token takes part in the scan. A chip that sees `start` while its token input is high runs its pattern from address 0. When it reaches a word marked end-of-chip, it pulses its token output to the next chip and falls quiet. The pattern memory is loaded through a three-wire serial port. The load is accepted only while the chip is idle.

Top module: `rowseq_top`

## Requirements
- R1: After reset, every gate and clear output is low, `tok_out` is low and `prog_err` is low.
- R2: In idle, a cycle with `start` and `tok_in` both high starts a pass at address 0, and word 0 shows on the outputs after that clock edge. A `start` with `tok_in` low is ignored.
- R3: Each cycle with `step` high during a pass moves to the next word. The words are shown in memory order, so a channel may appear many times or not at all.
- R4: At most one gate output and at most one clear output are high at any time. The high output is the one whose index equals the channel field, which is the low $clog2(NUM_CH) bits of the word.
- R5: A word whose gate bit (bit CW, where CW is the channel-field width) is 0 drives no gate output during its slot.
- R6: A word whose clear bit (bit CW+1) is 1 raises the clear output of its channel exactly GATE_CYC clocks after the slot begins. The output stays high until the slot ends. It is never high in the first GATE_CYC cycles of the slot.
- R7: A `step` on a word whose end-of-chip bit (the top bit, CW+2) is set ends the pass. `tok_out` is then high for exactly one cycle, all outputs go low, and the chip is idle.
- R8: While idle, all outputs stay low and `step` has no effect.
- R9: A load frame is FW = $clog2(DEPTH)+CW+3 bits, sent MSB first on `pg_bit` while `pg_sel` is high: the address, then the end-of-chip, clear and gate bits, then the channel. The frame is written when `pg_sel` falls after exactly FW bits. A frame of any other length is discarded.
- R10: A complete frame that arrives during a pass leaves the memory unchanged and sets `prog_err`, which stays set until reset. Frames that arrive while idle are written.
- R11: A `start` during a pass has no effect on the pass.
- R12: After the last address, the pointer wraps to address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pg_sel | input | 1 | Load frame select |
| pg_bit | input | 1 | Load serial data, MSB first |
| start | input | 1 | Shared pass start strobe |
| step | input | 1 | Shared row-advance strobe |
| tok_in | input | 1 | Token from the previous chip |
| tok_out | output | 1 | One-cycle token pulse to the next chip |
| prog_err | output | 1 | Sticky flag for a load refused during a pass |
| gate_en | output | NUM_CH | Per-channel gate enables |
| clear_en | output | NUM_CH | Per-channel clear enables |

## Verification
The bench builds the block with NUM_CH=16, DEPTH=8 and GATE_CYC=2. This makes a load frame 10 bits long and puts pointer wrap-around within a few slots. A GATE_CYC of 2 leaves a clear-free lead-in inside each slot that the bench can test cycle by cycle. Random patterns with random end-of-chip positions run alongside directed cases: skipped and repeated rows, a refused load during a pass, a truncated frame, and start and step strobes given in the wrong state.

// File: rtl/rowseq_pkg.sv
package rowseq_pkg;
    typedef enum logic {
        RS_IDLE = 1'b0,
        RS_RUN  = 1'b1
    } rs_state_t;
endpackage

// File: rtl/rowseq_loader.sv
module rowseq_loader #(
    parameter int FW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pg_sel,
    input  logic          pg_bit,
    output logic          frame_vld,
    output logic [FW-1:0] frame
);
    localparam int CNTW = $clog2(FW + 2);

    typedef struct packed {
        logic            sel;
        logic [CNTW-1:0] cnt;
        logic [FW-1:0]   sh;
    } ld_t;

    ld_t ld_d, ld_q;

    always_comb begin
        ld_d     = ld_q;
        ld_d.sel = pg_sel;
        if (pg_sel) begin
            ld_d.sh = {ld_q.sh[FW-2:0], pg_bit};
            if (!ld_q.sel) begin
                ld_d.cnt = CNTW'(1);
            end else if (ld_q.cnt <= CNTW'(FW)) begin
                ld_d.cnt = ld_q.cnt + CNTW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ld_q <= '0;
        else        ld_q <= ld_d;
    end

    assign frame_vld = ld_q.sel && !pg_sel && (ld_q.cnt == CNTW'(FW));
    assign frame     = ld_q.sh;

    AST_FRAME_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        frame_vld |-> $past(pg_sel)); // R9
endmodule

// File: rtl/rowseq_store.sv
module rowseq_store #(
    parameter int DEPTH = 64,
    parameter int WW    = 10,
    parameter int AW    = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [WW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [WW-1:0] rdata
);
    logic [WW-1:0] mem_d [DEPTH];
    logic [WW-1:0] mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (we) mem_d[waddr] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/rowseq_onehot.sv
module rowseq_onehot #(
    parameter int NUM_CH = 128,
    parameter int CW     = 7
) (
    input  logic              en,
    input  logic [CW-1:0]     idx,
    output logic [NUM_CH-1:0] vec
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        assign vec[i] = en && (idx == CW'(i));
    end
endmodule

// File: rtl/rowseq_top.sv
module rowseq_top
    import rowseq_pkg::*;
#(
    parameter int NUM_CH   = 128,
    parameter int DEPTH    = 64,
    parameter int GATE_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pg_sel,
    input  logic              pg_bit,
    input  logic              start,
    input  logic              step,
    input  logic              tok_in,
    output logic              tok_out,
    output logic              prog_err,
    output logic [NUM_CH-1:0] gate_en,
    output logic [NUM_CH-1:0] clear_en
);
    localparam int CW = $clog2(NUM_CH);
    localparam int AW = $clog2(DEPTH);
    localparam int WW = CW + 3;
    localparam int FW = AW + WW;
    localparam int PW = $clog2(GATE_CYC + 2);

    typedef struct packed {
        rs_state_t     st;
        logic [AW-1:0] ptr;
        logic [PW-1:0] ph;
        logic          tok;
        logic          err;
    } seq_t;

    seq_t s_d, s_q;

    logic          frame_vld;
    logic [FW-1:0] frame;
    logic [WW-1:0] word;
    logic          w_eoc, w_clr, w_gate;
    logic [CW-1:0] w_ch;
    logic          mem_we;

    rowseq_loader #(.FW(FW)) u_loader (
        .clk(clk), .rst_n(rst_n), .pg_sel(pg_sel), .pg_bit(pg_bit),
        .frame_vld(frame_vld), .frame(frame)
    );

    assign mem_we = frame_vld && (s_q.st == RS_IDLE);

    rowseq_store #(.DEPTH(DEPTH), .WW(WW), .AW(AW)) u_store (
        .clk(clk), .rst_n(rst_n), .we(mem_we),
        .waddr(frame[FW-1:WW]), .wdata(frame[WW-1:0]),
        .raddr(s_q.ptr), .rdata(word)
    );

    assign w_eoc  = word[WW-1];
    assign w_clr  = word[WW-2];
    assign w_gate = word[WW-3];
    assign w_ch   = word[CW-1:0];

    always_comb begin
        s_d     = s_q;
        s_d.tok = 1'b0;
        if (frame_vld && s_q.st == RS_RUN) s_d.err = 1'b1;
        case (s_q.st)
            RS_IDLE: begin
                if (start && tok_in) begin
                    s_d.st  = RS_RUN;
                    s_d.ptr = '0;
                    s_d.ph  = '0;
                end
            end
            default: begin
                if (step) begin
                    s_d.ph = '0;
                    if (w_eoc) begin
                        s_d.st  = RS_IDLE;
                        s_d.tok = 1'b1;
                    end else if (s_q.ptr == AW'(DEPTH - 1)) begin
                        s_d.ptr = '0;
                    end else begin
                        s_d.ptr = s_q.ptr + AW'(1);
                    end
                end else if (s_q.ph < PW'(GATE_CYC)) begin
                    s_d.ph = s_q.ph + PW'(1);
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: RS_IDLE, default: '0};
        else        s_q <= s_d;
    end

    rowseq_onehot #(.NUM_CH(NUM_CH), .CW(CW)) u_gate_dec (
        .en(s_q.st == RS_RUN && w_gate), .idx(w_ch), .vec(gate_en)
    );

    rowseq_onehot #(.NUM_CH(NUM_CH), .CW(CW)) u_clr_dec (
        .en(s_q.st == RS_RUN && w_clr && s_q.ph == PW'(GATE_CYC)),
        .idx(w_ch), .vec(clear_en)
    );

    assign tok_out  = s_q.tok;
    assign prog_err = s_q.err;

    AST_GATE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gate_en)); // R4
    AST_CLEAR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clear_en)); // R4
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == RS_IDLE) |-> (gate_en == '0 && clear_en == '0)); // R8
    AST_TOKEN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        tok_out |=> !tok_out); // R7
    AST_CLEAR_LATE: assert property (@(posedge clk) disable iff (!rst_n)
        (|clear_en) |-> $past(s_q.st == RS_RUN)); // R6
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        prog_err |=> prog_err); // R10
    AST_RUN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == RS_RUN && !step) |=> (s_q.st == RS_RUN)); // R11
endmodule

// File: tb/rowseq_top_test.sv
`timescale 1ns/1ps
module rowseq_top_test;
    localparam int NUM_CH   = 16;
    localparam int DEPTH    = 8;
    localparam int GATE_CYC = 2;
    localparam int CW = $clog2(NUM_CH);
    localparam int AW = $clog2(DEPTH);
    localparam int WW = CW + 3;
    localparam int FW = AW + WW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pg_sel = 1'b0, pg_bit = 1'b0, start = 1'b0, step = 1'b0, tok_in = 1'b0;
    logic tok_out, prog_err;
    logic [NUM_CH-1:0] gate_en, clear_en;

    int checks = 0;
    int errors = 0;
    logic [WW-1:0] model [DEPTH];

    always #2.5 clk = ~clk;

    rowseq_top #(.NUM_CH(NUM_CH), .DEPTH(DEPTH), .GATE_CYC(GATE_CYC)) uut (
        .clk(clk), .rst_n(rst_n), .pg_sel(pg_sel), .pg_bit(pg_bit),
        .start(start), .step(step), .tok_in(tok_in), .tok_out(tok_out),
        .prog_err(prog_err), .gate_en(gate_en), .clear_en(clear_en)
    );

    function automatic logic [NUM_CH-1:0] exp_gate(logic [WW-1:0] w);
        return w[CW] ? (NUM_CH'(1) << w[CW-1:0]) : '0;
    endfunction

    function automatic logic [NUM_CH-1:0] exp_clear(logic [WW-1:0] w);
        return w[CW+1] ? (NUM_CH'(1) << w[CW-1:0]) : '0;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; start = 0; step = 0; pg_sel = 0; tok_in = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic send(int addr, logic [WW-1:0] w, int nbits, bit upd);
        logic [FW-1:0] f;
        f = {AW'(addr), w};
        pg_sel = 1'b1;
        for (int i = nbits - 1; i >= 0; i--) begin
            pg_bit = f[i];
            @(negedge clk);
        end
        pg_sel = 1'b0;
        @(negedge clk);
        if (upd) model[addr] = w;
    endtask

    // Run a pass from address 0; optional injected load or start at slot 1.
    task automatic run(int max_slots, bit inj_wr, bit inj_start);
        int p = 0;
        logic [WW-1:0] w;
        tok_in = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0; tok_in = 1'b0;
        for (int s = 0; s < max_slots; s++) begin
            w = model[p];
            chk("R2/R3/R4/R5 gate at slot start", 32'(gate_en), 32'(exp_gate(w)));
            chk("R6 no clear in lead-in", 32'(clear_en), 32'h0);
            if (inj_start && s == 1) start = 1'b1;
            for (int k = 0; k < GATE_CYC; k++) begin
                @(negedge clk);
                start = 1'b0;
                if (k < GATE_CYC - 1)
                    chk("R6 clear still low", 32'(clear_en), 32'h0);
            end
            chk("R6 clear after lead-in", 32'(clear_en), 32'(exp_clear(w)));
            chk("R11 gate unchanged", 32'(gate_en), 32'(exp_gate(w)));
            if (inj_wr && s == 1) begin
                send((p + 1) % DEPTH, ~model[(p + 1) % DEPTH], FW, 1'b0);
                chk("R10 error flag set", 32'(prog_err), 32'h1);
                chk("R6 clear held", 32'(clear_en), 32'(exp_clear(w)));
            end
            step = 1'b1;
            @(negedge clk);
            step = 1'b0;
            if (w[WW-1]) begin
                chk("R7 token pulse", 32'(tok_out), 32'h1);
                chk("R7 gate low after end", 32'(gate_en), 32'h0);
                @(negedge clk);
                chk("R7 token one cycle", 32'(tok_out), 32'h0);
                return;
            end
            p = (p + 1) % DEPTH;
        end
    endtask

    task automatic load_all(logic [WW-1:0] ws [DEPTH]);
        for (int a = 0; a < DEPTH; a++) send(a, ws[a], FW, 1'b1);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [WW-1:0] ws [DEPTH];
        void'($urandom(32'd20240607));
        do_reset();
        // R1 reset state
        chk("R1 gate", 32'(gate_en), 0);
        chk("R1 clear", 32'(clear_en), 0);
        chk("R1 token", 32'(tok_out), 0);
        chk("R1 error", 32'(prog_err), 0);

        // Directed: skip rows, repeat row 3; end at word 5
        ws[0] = {3'b011, 4'd3}; ws[1] = {3'b001, 4'd5}; ws[2] = {3'b011, 4'd3};
        ws[3] = {3'b010, 4'd9}; ws[4] = {3'b001, 4'd3}; ws[5] = {3'b111, 4'd15};
        ws[6] = {3'b001, 4'd1}; ws[7] = {3'b001, 4'd2};
        load_all(ws);

        // R8 idle step ignored; R2 start without token ignored
        step = 1'b1; @(negedge clk); step = 1'b0; @(negedge clk);
        chk("R8 idle step no gate", 32'(gate_en), 0);
        start = 1'b1; @(negedge clk); start = 1'b0; @(negedge clk);
        chk("R2 start without token", 32'(gate_en), 0);

        run(DEPTH, 1'b0, 1'b0);
        chk("R8 idle after pass", 32'(gate_en | clear_en), 0);

        // R11 start during pass
        run(DEPTH, 1'b0, 1'b1);
        // R10 refused load during pass; later slot shows old content
        run(DEPTH, 1'b1, 1'b0);
        chk("R10 error sticky", 32'(prog_err), 1);

        // R9 truncated frame discarded; full idle frame accepted
        send(0, {3'b011, 4'd12}, FW - 1, 1'b0);
        send(1, {3'b001, 4'd7}, FW, 1'b1);
        run(DEPTH, 1'b0, 1'b0);

        // R12 wrap: no end-of-chip anywhere
        for (int a = 0; a < DEPTH; a++) ws[a] = {3'b011, CW'(a + 2)};
        load_all(ws);
        run(DEPTH + 3, 1'b0, 1'b0);
        do_reset();
        chk("R1 error cleared by reset", 32'(prog_err), 0);

        // Random patterns with random end position
        for (int r = 0; r < 25; r++) begin
            int e = $urandom_range(DEPTH - 1);
            for (int a = 0; a < DEPTH; a++) begin
                ws[a] = {1'b0, 1'($urandom), 1'($urandom_range(3) != 0),
                         CW'($urandom)};
                if (a == e) ws[a][WW-1] = 1'b1;
            end
            load_all(ws);
            run(DEPTH, 1'b0, 1'b0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule